// File: doc/BRIEF.md
# Column-at-a-time bit-plane loader

The block fills a square binary pixel memory of 256 columns by 256 rows, one column per step. Each clock that carries a valid 32-bit input word pushes one bit into each of thirty-two parallel 8-bit shift registers. After eight such words, the shift registers hold one complete 256-bit column word. The finished word is copied into a holding buffer. That buffer drives the column data bus and its bitwise complement. An address decoder then pulls exactly one active-low column enable low, so the pixel array stores the buffered word into that column.

Because the holding buffer is separate from the shift registers, the words of column n+1 stream in while column n is being written. With no gaps in the input, a whole bit-plane takes 2048 input clocks. A frame-start input returns both the column counter and the word counter to zero. A one-clock completion pulse marks the write of the last column. All state is static, so the input may stall for any length of time.

Top module: `col_loader`

## Requirements
- R1: While reset is held and after its release, all column enables are high (inactive), the data bus is 0, the complement bus is all ones, and scan_done_o is low.
- R2: Within a column, bit k of the j-th valid word (j = 0..7, counted since the last column completed or since frame start) lands on data bus bit k*8 + j.
- R3: The eighth valid word of a column moves the assembled 256-bit word into the holding buffer, which appears on col_data_o in the clock after the edge that accepts that word.
- R4: col_data_n_o is always the bitwise complement of col_data_o.
- R5: In the clock after each buffer transfer, exactly one bit of col_en_n_o is low: the bit whose index equals the column counter. In every other clock all enables are high.
- R6: The column counter starts at 0, advances by one after each enable clock, and wraps from 255 back to 0. One bit-plane therefore takes 256 enable pulses and 2048 valid words.
- R7: While the next column is being assembled, the buffer and data buses keep the previous column until the next column's eighth word.
- R8: In a clock with word_valid_i low, the word count, the shift registers and the buffer are left unchanged, for any length of stall.
- R9: scan_done_o is high for exactly one clock: the clock that follows the enable clock of column 255.
- R10: frame_start_i sets the column counter and the word count to 0 and cancels any pending transfer. A word presented in the same clock is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Clears the column and word counters |
| word_valid_i | input | 1 | word_i carries a word this clock |
| word_i | input | 32 | Input data word; bit k feeds shift register k |
| col_data_o | output | 256 | Buffered column word |
| col_data_n_o | output | 256 | Complement of col_data_o |
| col_en_n_o | output | 256 | Active-low column enables, at most one low |
| scan_done_o | output | 1 | One-clock pulse after column 255 is written |

## Verification
The hardest case to reach from the ports is the completion pulse, together with the wrap of the column counter. Both need 2048 accepted words with no frame start in between, so the bench drives a complete bit-plane with random data and random stall gaps. It then runs a second plane and checks that the enable index returns to 0. A frame start is also issued mid-column and mid-plane, to show that the partial column is discarded and that addressing restarts at column 0.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned DEPTH_DEF  = 8;
  localparam int unsigned NCOL_DEF   = 256;
endpackage

// File: rtl/col_shifter.sv
module col_shifter #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned COL_W = WORD_W * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [COL_W-1:0]  col_nxt_o
);
  for (genvar k = 0; k < WORD_W; k++) begin : g_lane
    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] sr_d;
    // newest bit enters at MSB; after DEPTH shifts word j sits at bit j
    assign sr_d = {word_i[k], sr_q[DEPTH-1:1]};
    assign col_nxt_o[k*DEPTH +: DEPTH] = sr_d;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (shift_i) sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/col_seq.sv
module col_seq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NCOL  = 256,
  localparam int unsigned BEAT_W = $clog2(DEPTH),
  localparam int unsigned ADDR_W = $clog2(NCOL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              word_valid_i,
  output logic              shift_o,
  output logic              load_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              done_o
);
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] col_q;
  logic              wr_q, done_q;

  assign shift_o = word_valid_i && !frame_start_i;
  assign load_o  = shift_o && (beat_q == BEAT_W'(DEPTH-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= wr_q && (col_q == ADDR_W'(NCOL-1));
      wr_q   <= load_o;
      if (frame_start_i) begin
        beat_q <= '0;
        col_q  <= '0;
      end else begin
        if (shift_o) beat_q <= load_o ? '0 : beat_q + 1'b1;
        if (wr_q)    col_q  <= (col_q == ADDR_W'(NCOL-1)) ? '0 : col_q + 1'b1;
      end
    end
  end

  assign wr_o   = wr_q;
  assign col_o  = col_q;
  assign beat_o = beat_q;
  assign done_o = done_q;
endmodule

// File: rtl/col_buffer.sv
module col_buffer #(
  parameter int unsigned COL_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] d_i,
  output logic [COL_W-1:0] q_o,
  output logic [COL_W-1:0] qn_o
);
  logic [COL_W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end
  assign q_o  = q;
  assign qn_o = ~q;
endmodule

// File: rtl/col_decoder.sv
module col_decoder #(
  parameter int unsigned NCOL = 256,
  localparam int unsigned ADDR_W = $clog2(NCOL)
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NCOL-1:0]   en_n_o
);
  for (genvar i = 0; i < NCOL; i++) begin : g_line
    assign en_n_o[i] = !(en_i && (addr_i == ADDR_W'(i)));
  end
endmodule

// File: rtl/col_loader.sv
module col_loader
  import col_loader_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned NCOL   = NCOL_DEF,
  localparam int unsigned COL_W  = WORD_W * DEPTH,
  localparam int unsigned ADDR_W = $clog2(NCOL),
  localparam int unsigned BEAT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [COL_W-1:0]  col_data_o,
  output logic [COL_W-1:0]  col_data_n_o,
  output logic [NCOL-1:0]   col_en_n_o,
  output logic              scan_done_o
);
  logic              shift, load, wr;
  logic [ADDR_W-1:0] col;
  logic [BEAT_W-1:0] beat_q;
  logic [COL_W-1:0]  col_nxt;

  col_seq #(.DEPTH(DEPTH), .NCOL(NCOL)) u_seq (
    .clk_i, .rst_ni, .frame_start_i, .word_valid_i,
    .shift_o(shift), .load_o(load), .wr_o(wr), .col_o(col),
    .beat_o(beat_q), .done_o(scan_done_o)
  );

  col_shifter #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_shift (
    .clk_i, .rst_ni, .shift_i(shift), .word_i, .col_nxt_o(col_nxt)
  );

  col_buffer #(.COL_W(COL_W)) u_buf (
    .clk_i, .rst_ni, .load_i(load), .d_i(col_nxt),
    .q_o(col_data_o), .qn_o(col_data_n_o)
  );

  col_decoder #(.NCOL(NCOL)) u_dec (
    .en_i(wr), .addr_i(col), .en_n_o(col_en_n_o)
  );
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned NCOL   = 256,
  localparam int unsigned COL_W  = WORD_W * DEPTH,
  localparam int unsigned BEAT_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              word_valid_i,
  input logic [BEAT_W-1:0] beat_i,
  input logic [COL_W-1:0]  col_data_o,
  input logic [NCOL-1:0]   col_en_n_o,
  input logic              scan_done_o
);
  AST_EN_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~col_en_n_o)); // R5
  AST_EN_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_en_n_o != '1) |-> $past(word_valid_i && !frame_start_i && beat_i == BEAT_W'(DEPTH-1))); // R5
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_valid_i) |-> $stable(col_data_o)); // R8
  AST_STALL_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_valid_i && !frame_start_i) |=> $stable(beat_i)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> $past(!col_en_n_o[NCOL-1])); // R9
  AST_FS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (beat_i == '0)); // R10
endmodule

bind col_loader col_loader_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .NCOL(NCOL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
  .word_valid_i(word_valid_i), .beat_i(beat_q), .col_data_o(col_data_o),
  .col_en_n_o(col_en_n_o), .scan_done_o(scan_done_o)
);

// File: tb/sim_col_loader.sv
module sim_col_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fs = 1'b0, vld = 1'b0;
  logic [31:0]  wd = '0;
  logic [255:0] dat, dat_n, en_n;
  logic         done;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  col_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .word_valid_i(vld),
    .word_i(wd), .col_data_o(dat), .col_data_n_o(dat_n),
    .col_en_n_o(en_n), .scan_done_o(done)
  );

  // behavioural reference
  logic [255:0] m_buf = '0;
  logic [31:0]  m_q[$];
  int  m_col = 0;
  bit  m_wr = 0, m_done = 0;
  int  n_en = 0, n_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [255:0] e_en;
    e_en = '1;
    if (m_wr) e_en[m_col] = 1'b0;
    chk(dat === m_buf, "R2 R3 R7 data", dat, m_buf);
    chk(dat_n === ~m_buf, "R4 complement", dat_n, ~m_buf);
    chk(en_n === e_en, "R5 R6 enable", en_n, e_en);
    chk(done === m_done, "R9 scan_done", 256'(done), 256'(m_done));
    if (en_n != '1) n_en++;
    if (done) n_done++;
  endtask

  // one clock: compare, drive, advance model to post-edge state
  task automatic step(input bit f, input bit v, input logic [31:0] w);
    @(negedge clk);
    compare();
    fs = f; vld = v; wd = w;
    m_done = m_wr && (m_col == 255);
    if (m_wr) m_col = (m_col + 1) % 256;
    m_wr = 0;
    if (f) begin
      m_col = 0;
      m_q.delete();
    end else if (v) begin
      m_q.push_back(w);
      if (m_q.size() == 8) begin
        for (int k = 0; k < 32; k++)
          for (int j = 0; j < 8; j++) m_buf[k*8+j] = m_q[j][k];
        m_q.delete();
        m_wr = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0);
  endtask

  task automatic column(input int gap);
    for (int j = 0; j < 8; j++) begin
      step(0, 1, $urandom);
      if (gap > 0) idle($urandom_range(gap));
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] held;
    int           e0, d0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(en_n === '1 && dat === '0 && dat_n === '1 && done === 1'b0, "R1 reset", en_n, '1);
    rst_n = 1'b1;
    idle(2);

    // R2 walking pattern: word j has bit k set for k%8==j -> rows k*8+j with k%8==j
    for (int j = 0; j < 8; j++) begin
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < 32; k++) if (k % 8 == j) w[k] = 1'b1;
      step(0, 1, w);
    end
    idle(1);
    begin
      logic [255:0] e;
      e = '0;
      for (int k = 0; k < 32; k++) e[k*8 + (k % 8)] = 1'b1;
      chk(dat === e, "R2 mapping", dat, e);
    end

    // R7 partial next column leaves buffer intact
    held = dat;
    for (int j = 0; j < 5; j++) step(0, 1, $urandom);
    idle(1);
    chk(dat === held, "R7 hold", dat, held);
    // R8 long stall then finish column
    idle(300);
    chk(dat === held, "R8 stall", dat, held);
    for (int j = 0; j < 3; j++) step(0, 1, $urandom);
    idle(1);
    chk(dat === m_buf, "R8 resume", dat, m_buf);

    // R10 mid-column frame start with word dropped, then column 0
    for (int j = 0; j < 3; j++) step(0, 1, $urandom);
    step(1, 1, 32'hFFFF_FFFF);
    n_en = 0;
    column(0);
    step(0, 0, '0);
    chk(en_n[0] === 1'b0 || n_en == 1, "R10 restart col0", en_n, ~256'd1);

    // full plane with stalls, then wrap
    step(1, 0, '0);
    e0 = n_en; d0 = n_done;
    for (int c = 0; c < 256; c++) column(c % 16 == 3 ? 3 : 0);
    idle(3);
    chk(n_en - e0 == 256, "R6 enables per plane", 256'(n_en - e0), 256'd256);
    chk(n_done - d0 == 1, "R9 one done per plane", 256'(n_done - d0), 256'd1);
    // continuous plane: 2048 words
    e0 = n_en;
    for (int c = 0; c < 256; c++) column(0);
    idle(3);
    chk(n_en - e0 == 256, "R6 continuous plane", 256'(n_en - e0), 256'd256);
    column(0);
    idle(3);
    // mid-plane frame start
    for (int c = 0; c < 10; c++) column(0);
    step(1, 0, '0);
    column(0);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule